// File: doc/BRIEF.md
# Comparator Control and Edge-Flag Interface

This block is the digital side of an on-chip voltage comparator. A single 16-bit read/write control word holds everything software chooses about the comparator. It turns the comparator on or off and picks the source for its inverting input. It also sets the response-speed code, switches hysteresis on or off, selects output polarity and chooses where the result goes. The analog circuit itself lives elsewhere. This block only drives its select lines and takes back its raw decision as an asynchronous one-bit input.

The raw decision passes through a synchroniser. The synchronised level, with the polarity choice applied, can be routed to an output pin. The block also records transitions of the synchronised decision in two sticky flags, one for rising and one for falling edges. Software clears each flag by writing a one to its bit. When the routing selects interrupt mode, either flag raises the interrupt request.

Top module: `vcmp_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000, and the pin output, the interrupt request and all select outputs are low.
- R2: Bits 15:11 of the control word ignore writes and always read as 0.
- R3: Bit 10 drives `cmp_enable`. Bits 9:8 drive `neg_sel`, where 00 selects half supply, 01 an ADC input, 10 a DAC output and 11 is reserved. All control bits 10:2 hold their value until the next write.
- R4: Bits 4:3 drive `resp_sel`, where 00 is slow, 11 is fast and 01/10 are reserved. Bit 2 drives `hyst_on`.
- R5: The raw comparator input is resynchronised by two register stages. A change on `cmp_raw` reaches `cmp_pin` after the second rising clock edge.
- R6: Bit 5 selects polarity. With bit 5 at 0, `cmp_pin` follows the synchronised decision. With bit 5 at 1, `cmp_pin` is its inverse.
- R7: The routing code in bits 7:6 decides the pin. Code 10 drives `cmp_pin` while the comparator is enabled. Under any other code, or while disabled, `cmp_pin` is low.
- R8: Bit 1 becomes 1 one clock after the synchronised decision rises, and bit 0 does the same after it falls. Each flag stays at 1 until cleared.
- R9: While bit 10 is 0, no edge of the decision sets either flag.
- R10: Writing 1 to bit 1 or bit 0 clears that flag. Writing 0 to it leaves the flag unchanged.
- R11: When a new edge and a write-1 clear of the same flag meet in one cycle, the flag ends at 1.
- R12: `cmp_irq` is high exactly when the routing code is 11 and at least one edge flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current control word and flags |
| cmp_raw | input | 1 | Asynchronous comparator decision |
| cmp_enable | output | 1 | Comparator enable |
| neg_sel | output | 2 | Inverting-input source select |
| resp_sel | output | 2 | Response-time code |
| hyst_on | output | 1 | Hysteresis enable |
| cmp_pin | output | 1 | Routed comparator output |
| cmp_irq | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs: `cmp_raw` is only meaningful once it has crossed the synchroniser, the write strobe is a clean single-cycle-per-word level, and reset is held for more than one clock so the synchroniser stages start from known values. The stimulus meets these conditions. Every input, including the asynchronous comparator level, changes on the falling clock edge. Reset is held for several cycles. The coincidence of an edge with a clear is produced by a deliberate cycle count, not left to chance.

// File: rtl/vcmp_pkg.sv
// Package: field positions and types for the comparator control word.
// Assumes the control fields occupy one contiguous range, bits 10 down to 2.
package vcmp_pkg;
    localparam int REG_W     = 16;
    localparam int EN_BIT    = 10;
    localparam int HYST_BIT  = 2;
    localparam int RISE_BIT  = 1;
    localparam int FALL_BIT  = 0;
    localparam int CTRL_W    = EN_BIT - HYST_BIT + 1;
    localparam int FLAG_W    = 2;
    localparam int RSV_W     = REG_W - CTRL_W - FLAG_W;

    typedef enum logic [1:0] {
        ROUTE_RSV0 = 2'b00,
        ROUTE_RSV1 = 2'b01,
        ROUTE_PIN  = 2'b10,
        ROUTE_IRQ  = 2'b11
    } route_e;

    typedef enum logic [1:0] {
        NSEL_HALF = 2'b00,
        NSEL_ADC  = 2'b01,
        NSEL_DAC  = 2'b10,
        NSEL_RSV  = 2'b11
    } nsel_e;

    // Member order matches bit order 10..2 of the control word.
    typedef struct packed {
        logic        en;
        nsel_e       nsel;
        route_e      route;
        logic        pol;
        logic [1:0]  resp;
        logic        hyst;
    } ctrl_t;
endpackage

// File: rtl/vcmp_sync.sv
// Module: multi-stage synchroniser for an asynchronous level.
// Assumes STAGES >= 2 and that the input is a slowly varying level.
module vcmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] sh_q;

    // Shift the asynchronous level through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], async_i};
    end

    assign sync_o = sh_q[STAGES-1];

    assert_sync_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q[STAGES-2] |=> sh_q[STAGES-1]);
    assert_sync_stage_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_q[STAGES-2] |=> !sh_q[STAGES-1]);
endmodule

// File: rtl/vcmp_regs.sv
// Module: control word storage, read mux and write-1-clear strobes.
// Assumes one write per strobed cycle; reserved bits are never stored.
module vcmp_regs
    import vcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [FLAG_W-1:0] flags,
    output ctrl_t             ctrl,
    output logic [FLAG_W-1:0] clr,
    output logic [REG_W-1:0]  rd_data
);
    // Capture writable control fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl <= '0;
        else if (wr_en) ctrl <= ctrl_t'(wr_data[EN_BIT:HYST_BIT]);
    end

    // Form the per-flag clear strobes from the written ones.
    always_comb begin
        clr = '0;
        if (wr_en) clr = wr_data[FLAG_W-1:0];
    end

    // Assemble the read value with reserved bits as zero.
    always_comb rd_data = {{RSV_W{1'b0}}, ctrl, flags};

    assert_enable_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl.en == $past(wr_data[EN_BIT])));
    assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl));
    assert_hyst_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl.hyst == $past(wr_data[HYST_BIT])));
    assert_resv_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (|wr_data[REG_W-1:EN_BIT+1])) |=> (rd_data[REG_W-1:EN_BIT+1] == '0));
endmodule

// File: rtl/vcmp_edge.sv
// Module: edge detector with sticky rising/falling flags.
// Assumes `level` is already synchronous; flag[1] = rising, flag[0] = falling.
module vcmp_edge
    import vcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              level,
    input  logic [FLAG_W-1:0] clr,
    output logic [FLAG_W-1:0] flags
);
    logic              prev_q;
    logic [FLAG_W-1:0] set_v;

    // Remember the previous synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    // Decode enabled edges into per-flag set requests.
    always_comb begin
        set_v[RISE_BIT] = en &  level & ~prev_q;
        set_v[FALL_BIT] = en & ~level &  prev_q;
    end

    for (genvar g = 0; g < FLAG_W; g++) begin : g_flag
        // Sticky flag: set dominates a write-1 clear.
        always_ff @(posedge clk) begin
            if (!rst_n) flags[g] <= 1'b0;
            else        flags[g] <= set_v[g] | (flags[g] & ~clr[g]);
        end

        assert_edge_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
            set_v[g] |=> flags[g]);
        assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!en && !flags[g]) |=> !flags[g]);
        assert_clear_works_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[g] && clr[g] && !set_v[g]) |=> !flags[g]);
        assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (set_v[g] && clr[g]) |=> flags[g]);
    end
endmodule

// File: rtl/vcmp_route.sv
// Module: polarity and output routing to pin or interrupt request.
// Assumes inputs are registered; outputs are combinational from them.
module vcmp_route
    import vcmp_pkg::*;
(
    input  logic              en,
    input  route_e            route,
    input  logic              pol,
    input  logic              level,
    input  logic [FLAG_W-1:0] flags,
    output logic              pin,
    output logic              irq
);
    // Drive the pin with the polarity-adjusted level in pin mode only.
    always_comb pin = en && (route == ROUTE_PIN) && (level ^ pol);

    // Raise the request when in interrupt mode and any flag is pending.
    always_comb irq = (route == ROUTE_IRQ) && (|flags);
endmodule

// File: rtl/vcmp_ctrl.sv
// Module: top of the comparator control and edge-flag interface.
// Assumes cmp_raw is asynchronous; reset is synchronous, active low.
module vcmp_ctrl
    import vcmp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              cmp_raw,
    output logic              cmp_enable,
    output logic [1:0]        neg_sel,
    output logic [1:0]        resp_sel,
    output logic              hyst_on,
    output logic              cmp_pin,
    output logic              cmp_irq
);
    ctrl_t             ctrl;
    logic [FLAG_W-1:0] clr;
    logic [FLAG_W-1:0] flags;
    logic              level;

    vcmp_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_data(reg_wdata),
        .flags(flags), .ctrl(ctrl), .clr(clr), .rd_data(reg_rdata)
    );

    vcmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(cmp_raw), .sync_o(level)
    );

    vcmp_edge u_edge (
        .clk(clk), .rst_n(rst_n), .en(ctrl.en), .level(level),
        .clr(clr), .flags(flags)
    );

    vcmp_route u_route (
        .en(ctrl.en), .route(ctrl.route), .pol(ctrl.pol), .level(level),
        .flags(flags), .pin(cmp_pin), .irq(cmp_irq)
    );

    // Expose analog control selects straight from the control word.
    always_comb begin
        cmp_enable = ctrl.en;
        neg_sel    = ctrl.nsel;
        resp_sel   = ctrl.resp;
        hyst_on    = ctrl.hyst;
    end

    assert_irq_needs_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0 && !(cmp_enable && level != u_edge.prev_q)) |=> !cmp_irq);
endmodule

// File: tb/vcmp_ctrl_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus directed cases.
module vcmp_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cmp_raw = 1'b0;
    logic        cmp_enable, hyst_on, cmp_pin, cmp_irq;
    logic [1:0]  neg_sel, resp_sel;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vcmp_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cmp_raw(cmp_raw), .cmp_enable(cmp_enable),
        .neg_sel(neg_sel), .resp_sel(resp_sel), .hyst_on(hyst_on),
        .cmp_pin(cmp_pin), .cmp_irq(cmp_irq)
    );

    // Reference model state
    logic [15:0] m_ctrl = '0;
    logic [1:0]  m_flags = '0;
    bit          hist[$];
    bit          m_prev = 0;
    bit          mvalid = 0;

    function automatic bit m_level();
        return hist.size() >= 2 ? hist[hist.size()-2] : 1'b0;
    endfunction

    always @(posedge clk) begin
        bit lvl, nr, nf;
        if (!rst_n) begin
            m_ctrl = '0; m_flags = '0; m_prev = 0; hist = {};
        end else begin
            lvl = m_level();
            nr = m_ctrl[10] && lvl && !m_prev;
            nf = m_ctrl[10] && !lvl && m_prev;
            m_flags[1] = nr | (m_flags[1] & !(reg_wr & reg_wdata[1]));
            m_flags[0] = nf | (m_flags[0] & !(reg_wr & reg_wdata[0]));
            if (reg_wr) m_ctrl = reg_wdata & 16'h07FC;
            m_prev = lvl;
            hist.push_back(cmp_raw);
            if (hist.size() > 4) void'(hist.pop_front());
        end
        mvalid = 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (mvalid && !done) begin
            bit e_pin, e_irq;
            e_pin = m_ctrl[10] && m_ctrl[7:6] == 2'b10 && (m_level() ^ m_ctrl[5]);
            e_irq = m_ctrl[7:6] == 2'b11 && (|m_flags);
            chk(reg_rdata[15:2] == m_ctrl[15:2], "R3 ctrl", reg_rdata, m_ctrl);
            chk(reg_rdata[1:0] == m_flags, "R8 flags", reg_rdata[1:0], m_flags);
            chk(cmp_pin == e_pin, "R7 pin", cmp_pin, e_pin);
            chk(cmp_irq == e_irq, "R12 irq", cmp_irq, e_irq);
            chk({cmp_enable, neg_sel} == {m_ctrl[10], m_ctrl[9:8]}, "R3 selects",
                {cmp_enable, neg_sel}, {m_ctrl[10], m_ctrl[9:8]});
            chk({resp_sel, hyst_on} == m_ctrl[4:2], "R4 selects", {resp_sel, hyst_on}, m_ctrl[4:2]);
        end
    end

    // Caller stands at a falling edge; returns one falling edge later.
    task automatic wr(input logic [15:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        chk(reg_rdata == 16'h0000 && !cmp_pin && !cmp_irq, "R1 reset", reg_rdata, 0);

        wr(16'hFFFF);
        chk(reg_rdata == 16'h07FC, "R2 reserved", reg_rdata, 16'h07FC);

        wr(16'h0500);
        chk(neg_sel == 2'b01 && cmp_enable, "R3 adc select", neg_sel, 1);
        wr(16'h0600);
        chk(neg_sel == 2'b10, "R3 dac select", neg_sel, 2);
        wr(16'h001C);
        chk(resp_sel == 2'b11 && hyst_on && !cmp_enable, "R4 fast+hyst", {resp_sel, hyst_on}, 7);

        wr(16'h0480);
        cmp_raw = 1'b1;
        step(1);
        chk(cmp_pin == 1'b0, "R5 one stage", cmp_pin, 0);
        step(1);
        chk(cmp_pin == 1'b1, "R5 two stages", cmp_pin, 1);
        chk(reg_rdata[1] == 1'b0, "R8 flag not yet", reg_rdata[1], 0);
        step(1);
        chk(reg_rdata[1] == 1'b1, "R8 rise flag", reg_rdata[1], 1);

        wr(16'h04A0);
        chk(cmp_pin == 1'b0, "R6 inverted", cmp_pin, 0);
        chk(reg_rdata[1] == 1'b1, "R10 write 0 keeps", reg_rdata[1], 1);
        wr(16'h04A2);
        chk(reg_rdata[1:0] == 2'b00, "R10 write 1 clears", reg_rdata[1:0], 0);

        wr(16'h00A0);
        cmp_raw = 1'b0;
        step(6);
        chk(reg_rdata[1:0] == 2'b00 && !cmp_pin, "R9 fall ignored", reg_rdata[1:0], 0);
        cmp_raw = 1'b1;
        step(6);
        chk(reg_rdata[1:0] == 2'b00, "R9 rise ignored", reg_rdata[1:0], 0);

        wr(16'h04C0);
        cmp_raw = 1'b0;
        step(2);
        wr(16'h04C1);
        chk(reg_rdata[0] == 1'b1, "R11 set wins", reg_rdata[0], 1);
        chk(cmp_irq == 1'b1, "R12 irq raised", cmp_irq, 1);
        wr(16'h04C1);
        chk(reg_rdata[0] == 1'b0 && !cmp_irq, "R12 irq drops", cmp_irq, 0);

        for (int i = 0; i < 600; i++) begin
            reg_wr = ($urandom % 6 == 0);
            reg_wdata = 16'($urandom);
            if ($urandom % 4 == 0) cmp_raw = ~cmp_raw;
            @(negedge clk);
        end
        reg_wr = 1'b0;
        step(2);
        finish_run();
    end
endmodule